// File: doc/BRIEF.md
# Multi-Window Message Send Sequencer

This block pushes a message of 32-bit words, with a length given in bytes, through a contiguous group of mailbox channel windows. It takes the words one at a time from a valid/ready stream and collects up to one window group's worth into a round buffer. It waits until the highest window of the group reads empty. Then it issues one register write per cycle: a window index and a data word. The first word of a round belongs to the highest window. That window is the only one left unmasked at the receiver, so its write is issued last and it raises the receiver interrupt. Messages longer than the group are sent as several rounds, and the block waits for the top window to drain before each one.

A message whose leading word, after partial-byte masking, is zero is refused. A zero written to the triggering window would never raise the receiver's interrupt. The refused message's words are still pulled from the stream, so the stream stays aligned for the next message. A zero-length request is refused at once.

The controller is a five-state machine:
- IDLE: waiting for `start`.
- FILL: taking the words of one round.
- WAIT: polling the top window until it is empty.
- WRITE: issuing the round's writes.
- DRAIN: discarding the words of a refused message.

Its transitions are:
- IDLE→FILL on an accepted start.
- IDLE→IDLE with a reject pulse on a zero length.
- FILL→WAIT when the round's last word is taken.
- FILL→DRAIN, or FILL→IDLE with a reject pulse, on a zero leading word.
- WAIT→WRITE when the top status is zero.
- WRITE→FILL after a round's top write when bytes remain.
- WRITE→IDLE with done when no bytes remain.
- DRAIN→IDLE with a reject pulse after the last word.

Top module: `msg_window_sender`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `word_ready`, `wr_en`, `done` and `reject` are all 0.
- R2: A message of L bytes is carried as ceil(L/4) words, in rounds of at most NUM_WIN words each. `done` is high for exactly one cycle per message, in the same cycle as the final write, and that write goes to the top window.
- R3: Word j of a round, counting the first received word of the round as j=0, is written to window `WIN_BASE + NUM_WIN - 1 - j`. Its data is unchanged apart from R6.
- R4: A round's writes come in consecutive cycles, with the window index rising by one each cycle. The top window is written last, and the cycle after a top-window write carries no write.
- R5: A round of k < NUM_WIN words writes only the top k windows. Windows below `WIN_BASE + NUM_WIN - k` are not written.
- R6: Let r = L mod 4. When r is not 0, the message's final word keeps bytes 0 to r-1 (byte b is bits 8b+7:8b), and all its other bits are sent as zero.
- R7: The first write of every round comes only after a cycle in which `top_stat` was zero. No write is issued while `top_stat` stays nonzero.
- R8: A message whose first word is zero after R6 masking produces no window write and no `done`. All of its ceil(L/4) words are still accepted. `reject` pulses for one cycle after the last of them, and the next message is sent normally.
- R9: A `start` with `msg_len` of 0 gives a one-cycle `reject` in the next cycle. It consumes no word, and `busy` stays 0.
- R10: `start` is ignored while `busy` is high. The message in flight is written unchanged, and no second message begins.
- R11: `busy` is high from the cycle after an accepted start until the cycle after `done`, or until the cycle of `reject`. `word_ready` is high only while busy, and a word is taken only on a cycle with `word_valid` and `word_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send a message of `msg_len` bytes |
| msg_len | input | LEN_W | Message length in bytes, 0 to MAX_BYTES |
| word_valid | input | 1 | Message word present on `word_data` |
| word_data | input | WORD_W | Next message word, in message order |
| word_ready | output | 1 | Block takes the word this cycle if valid |
| top_stat | input | WORD_W | Current status of the group's top window; zero means drained |
| wr_en | output | 1 | Window register write strobe |
| wr_win | output | IDX_W | Absolute index of the window being written |
| wr_data | output | WORD_W | Data for the window write |
| busy | output | 1 | A message is in progress |
| done | output | 1 | One-cycle pulse with the message's final write |
| reject | output | 1 | One-cycle pulse for a refused message |

## Verification
The bench goes after several corner cases:
- A single-word message, and a round shorter than the group. A design that fills from the bottom would write low windows and miss the interrupt window.
- Lengths that are not a multiple of four. Unmasked upper bytes would leak stale data.
- A 26-byte and a 256-byte message with a slow receiver. A sequencer that skips the drain poll would overwrite the top window before it is read, and a broken round count would leave words unsent.
- Zero leading words, including one that becomes zero only through masking, a zero length, and a start issued mid-message. A faulty design would write a silent message, lose stream alignment, or start a second message over the first.

// File: rtl/msg_seq_pkg.sv
package msg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DRAIN = 3'd4
    } seq_state_e;

    // Words carried by the next round: ceil(bytes / bytes-per-word), capped
    // at the number of windows in the group.
    function automatic int words_in_round(int nbytes, int nwin, int bpw);
        int w;
        w = (nbytes + bpw - 1) / bpw;
        if (w > nwin) begin
            w = nwin;
        end
        return w;
    endfunction

endpackage

// File: rtl/msg_word_mask.sv
module msg_word_mask #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 9
) (
    input  logic [WORD_W-1:0] raw_word,
    input  logic [LEN_W-1:0]  bytes_left,
    output logic [WORD_W-1:0] kept_word
);
    localparam int BPW = WORD_W / 8;

    // A byte lane survives only if the message still owns that byte.
    for (genvar b = 0; b < BPW; b++) begin : g_lane
        logic keep;
        assign keep = (bytes_left > LEN_W'(b));
        assign kept_word[b*8 +: 8] = keep ? raw_word[b*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/msg_round_buf.sv
module msg_round_buf #(
    parameter int NUM_WIN = 4,
    parameter int WORD_W  = 32,
    parameter int AW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] slot [NUM_WIN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_WIN; s++) begin
                slot[s] <= '0;
            end
        end else if (we) begin
            slot[idx] <= wdata;
        end
    end

    assign rdata = slot[idx];

endmodule

// File: rtl/msg_seq_fsm.sv
module msg_seq_fsm
    import msg_seq_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int WORD_W  = 32,
    parameter int LEN_W   = 9,
    parameter int AW      = 2,
    parameter int CNT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  msg_len,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] kept_word,
    input  logic              top_clear,
    output logic              word_ready,
    output logic              busy,
    output logic              done,
    output logic              reject,
    output logic              buf_we,
    output logic [AW-1:0]     buf_idx,
    output logic              wr_en,
    output logic [AW-1:0]     wr_off,
    output logic [LEN_W-1:0]  bytes_left
);
    localparam int BPW = WORD_W / 8;

    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] bytes_q, bytes_d, step;
    logic [CNT_W-1:0] rnd_q, rnd_d;
    logic [AW-1:0]    idx_q, idx_d;
    logic             first_q, first_d;
    logic             reject_q, reject_d;
    logic             fill_last;
    logic             last_in_msg;

    assign step        = (bytes_q > LEN_W'(BPW)) ? LEN_W'(BPW) : bytes_q;
    assign fill_last   = (CNT_W'(idx_q) == (rnd_q - CNT_W'(1)));
    assign last_in_msg = (bytes_q <= LEN_W'(BPW));

    // Next-state and counter logic
    always_comb begin
        state_d  = state_q;
        bytes_d  = bytes_q;
        rnd_d    = rnd_q;
        idx_d    = idx_q;
        first_d  = first_q;
        reject_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (msg_len == '0) begin
                        reject_d = 1'b1;
                    end else begin
                        bytes_d = msg_len;
                        rnd_d   = CNT_W'(words_in_round(int'(msg_len), NUM_WIN, BPW));
                        idx_d   = '0;
                        first_d = 1'b1;
                        state_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (word_valid) begin
                    bytes_d = bytes_q - step;
                    first_d = 1'b0;
                    if (first_q && (kept_word == '0)) begin
                        if (last_in_msg) begin
                            reject_d = 1'b1;
                            state_d  = ST_IDLE;
                        end else begin
                            state_d = ST_DRAIN;
                        end
                    end else if (fill_last) begin
                        state_d = ST_WAIT;
                    end else begin
                        idx_d = idx_q + AW'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (top_clear) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (idx_q == '0) begin
                    if (bytes_q == '0) begin
                        state_d = ST_IDLE;
                    end else begin
                        rnd_d   = CNT_W'(words_in_round(int'(bytes_q), NUM_WIN, BPW));
                        state_d = ST_FILL;
                    end
                end else begin
                    idx_d = idx_q - AW'(1);
                end
            end
            ST_DRAIN: begin
                if (word_valid) begin
                    bytes_d = bytes_q - step;
                    if (last_in_msg) begin
                        reject_d = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bytes_q  <= '0;
            rnd_q    <= '0;
            idx_q    <= '0;
            first_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            bytes_q  <= bytes_d;
            rnd_q    <= rnd_d;
            idx_q    <= idx_d;
            first_q  <= first_d;
            reject_q <= reject_d;
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        word_ready = (state_q == ST_FILL) || (state_q == ST_DRAIN);
        buf_we     = (state_q == ST_FILL) && word_valid;
        buf_idx    = idx_q;
        wr_en      = (state_q == ST_WRITE);
        wr_off     = AW'(NUM_WIN - 1) - idx_q;
        done       = (state_q == ST_WRITE) && (idx_q == '0) && (bytes_q == '0);
        reject     = reject_q;
        bytes_left = bytes_q;
    end

    // R8
    done_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && reject));

    // R11
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(done) || reject));

endmodule

// File: rtl/msg_window_sender.sv
module msg_window_sender #(
    parameter int NUM_WIN   = 4,
    parameter int WIN_BASE  = 2,
    parameter int IDX_W     = 7,
    parameter int WORD_W    = 32,
    parameter int MAX_BYTES = 256,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  msg_len,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic [WORD_W-1:0] top_stat,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_win,
    output logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              reject
);
    localparam int AW    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int CNT_W = $clog2(NUM_WIN + 1);
    localparam logic [IDX_W-1:0] TOP_WIN = IDX_W'(WIN_BASE + NUM_WIN - 1);

    logic [WORD_W-1:0] kept_word;
    logic [LEN_W-1:0]  bytes_left;
    logic              buf_we;
    logic [AW-1:0]     buf_idx;
    logic [AW-1:0]     wr_off;
    logic              top_clear;

    assign top_clear = (top_stat == '0);

    msg_word_mask #(
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) u_mask (
        .raw_word   (word_data),
        .bytes_left (bytes_left),
        .kept_word  (kept_word)
    );

    msg_round_buf #(
        .NUM_WIN (NUM_WIN),
        .WORD_W  (WORD_W),
        .AW      (AW)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .idx   (buf_idx),
        .wdata (kept_word),
        .rdata (wr_data)
    );

    msg_seq_fsm #(
        .NUM_WIN (NUM_WIN),
        .WORD_W  (WORD_W),
        .LEN_W   (LEN_W),
        .AW      (AW),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .msg_len    (msg_len),
        .word_valid (word_valid),
        .kept_word  (kept_word),
        .top_clear  (top_clear),
        .word_ready (word_ready),
        .busy       (busy),
        .done       (done),
        .reject     (reject),
        .buf_we     (buf_we),
        .buf_idx    (buf_idx),
        .wr_en      (wr_en),
        .wr_off     (wr_off),
        .bytes_left (bytes_left)
    );

    assign wr_win = IDX_W'(WIN_BASE) + IDX_W'(wr_off);

    // R3
    win_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_win >= IDX_W'(WIN_BASE)) && (wr_win <= TOP_WIN)));

    // R4
    win_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_win == $past(wr_win) + IDX_W'(1)));

    // R4
    top_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_win == TOP_WIN)) |=> !wr_en);

    // R7
    wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> ($past(top_stat) == '0));

    // R2
    done_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_en && (wr_win == TOP_WIN)));

endmodule

// File: tb/msg_window_sender_tb.sv
`timescale 1ns/1ps
module msg_window_sender_tb;
    localparam int NW    = 4;
    localparam int BASE  = 2;
    localparam int IDX_W = 7;
    localparam int MAXB  = 256;
    localparam int LEN_W = 9;
    localparam logic [IDX_W-1:0] TOP = IDX_W'(BASE + NW - 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  msg_len = '0;
    logic              word_valid = 1'b0;
    logic [31:0]       word_data = '0;
    logic              word_ready;
    logic [31:0]       top_stat;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_win;
    logic [31:0]       wr_data;
    logic              busy, done, reject;

    int checks = 0;
    int fails  = 0;
    int wd_cyc = 0;
    int cyc    = 0;

    logic [31:0]      msg     [64];
    logic [IDX_W-1:0] log_win [128];
    logic [31:0]      log_dat [128];
    int               log_cyc [128];
    int               log_n = 0;
    int               done_n = 0;
    int               rej_n = 0;
    logic [IDX_W-1:0] exp_win [128];
    logic [31:0]      exp_dat [128];
    int               exp_n = 0;

    int   stat_cnt   = 0;
    int   rx_delay   = 0;
    logic force_stat = 1'b0;

    assign top_stat = (force_stat || (stat_cnt != 0)) ? 32'h0000_0001 : 32'h0;

    msg_window_sender #(
        .NUM_WIN   (NW),
        .WIN_BASE  (BASE),
        .IDX_W     (IDX_W),
        .WORD_W    (32),
        .MAX_BYTES (MAXB),
        .LEN_W     (LEN_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .msg_len    (msg_len),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .top_stat   (top_stat),
        .wr_en      (wr_en),
        .wr_win     (wr_win),
        .wr_data    (wr_data),
        .busy       (busy),
        .done       (done),
        .reject     (reject)
    );

    always #2.5 clk = ~clk;

    // Monitor and receiver status model
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (wr_en && log_n < 128) begin
            log_win[log_n] = wr_win;
            log_dat[log_n] = wr_data;
            log_cyc[log_n] = cyc;
            log_n = log_n + 1;
        end
        if (done)   done_n = done_n + 1;
        if (reject) rej_n  = rej_n + 1;
        if (wr_en && wr_win == TOP) stat_cnt = rx_delay;
        else if (stat_cnt != 0)     stat_cnt = stat_cnt - 1;
    end

    always @(posedge clk) begin
        wd_cyc = wd_cyc + 1;
        if (wd_cyc > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not complete act=%0d exp<150000", wd_cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_word(input logic [31:0] w, input int len, input int idx);
        int nw;
        int r;
        logic [31:0] m;
        nw = (len + 3) / 4;
        r  = len % 4;
        m  = w;
        if (idx == nw - 1 && r != 0) begin
            for (int b = r; b < 4; b++) m[b*8 +: 8] = 8'h00;
        end
        return m;
    endfunction

    task automatic build_exp(input int len);
        int nw;
        int base_w;
        int k;
        nw = (len + 3) / 4;
        base_w = 0;
        exp_n = 0;
        while (base_w < nw) begin
            k = (nw - base_w < NW) ? (nw - base_w) : NW;
            for (int j = k - 1; j >= 0; j--) begin
                exp_win[exp_n] = IDX_W'(BASE + NW - 1 - j);
                exp_dat[exp_n] = mask_word(msg[base_w + j], len, base_w + j);
                exp_n = exp_n + 1;
            end
            base_w = base_w + k;
        end
    endtask

    // Runs one message; extra_start pulses a second start mid-message,
    // hold keeps the top window busy after feeding for that many cycles.
    task automatic send(input int len, input bit extra_start, input int hold);
        int nw;
        int i;
        bit taken;
        log_n = 0; done_n = 0; rej_n = 0;
        nw = (len + 3) / 4;
        @(negedge clk);
        start = 1'b1;
        msg_len = LEN_W'(len);
        @(negedge clk);
        #1;
        start = 1'b0;
        // R11
        chk(busy == 1'b1, "R11 busy after start", 32'(busy), 32'd1);
        i = 0;
        while (i < nw) begin
            if (extra_start && i == 0) begin
                start = 1'b1;
                msg_len = LEN_W'(4);
            end else begin
                start = 1'b0;
            end
            word_valid = 1'b1;
            word_data  = msg[i];
            taken = word_ready;
            @(negedge clk);
            #1;
            if (taken) i = i + 1;
        end
        word_valid = 1'b0;
        start = 1'b0;
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            #1;
            // R7
            chk(log_n == 0, "R7 no write while top busy", 32'(log_n), 32'd0);
            force_stat = 1'b0;
        end
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            #1;
            if (!busy && (done_n + rej_n) != 0) break;
        end
        // R11
        chk(busy == 1'b0 && word_ready == 1'b0, "R11 idle after message",
            {30'd0, busy, word_ready}, 32'd0);
    endtask

    task automatic compare_log(input string req);
        chk(log_n == exp_n, {req, " write count"}, 32'(log_n), 32'(exp_n));
        for (int i = 0; i < exp_n; i++) begin
            chk(log_win[i] === exp_win[i], {req, " window"}, 32'(log_win[i]), 32'(exp_win[i]));
            chk(log_dat[i] === exp_dat[i], {req, " data"}, log_dat[i], exp_dat[i]);
        end
        // R2
        chk(done_n == 1, {req, " R2 one done"}, 32'(done_n), 32'd1);
        chk(rej_n == 0, {req, " no reject"}, 32'(rej_n), 32'd0);
    endtask

    task automatic t_reset();
        #1;
        // R1
        chk({busy, word_ready, wr_en, done, reject} == 5'b0, "R1 reset outputs",
            32'({busy, word_ready, wr_en, done, reject}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk({busy, word_ready, wr_en, done, reject} == 5'b0, "R1 after reset",
            32'({busy, word_ready, wr_en, done, reject}), 32'd0);
    endtask

    task automatic t_single();
        msg[0] = 32'hA5A5_0001;
        build_exp(4);
        send(4, 1'b0, 0);
        // R3 R5: only the top window is written
        compare_log("R3 R5 single word");
    endtask

    task automatic t_full();
        for (int i = 0; i < 4; i++) msg[i] = 32'h1111_0000 + 32'(i + 1);
        build_exp(16);
        send(16, 1'b0, 0);
        // R3 R4: windows 2,3,4,5 receive words 3,2,1,0
        compare_log("R3 R4 full round");
    endtask

    task automatic t_partial();
        msg[0] = 32'hDEAD_BEEF;
        msg[1] = 32'hCAFE_F00D;
        build_exp(7);
        send(7, 1'b0, 0);
        // R5 R6: window 4 gets 0x00FEF00D, window 5 gets 0xDEADBEEF
        compare_log("R5 R6 partial");
        chk(exp_dat[0] == 32'h00FE_F00D, "R6 mask model", exp_dat[0], 32'h00FE_F00D);
    endtask

    task automatic t_multi();
        int gap;
        for (int i = 0; i < 7; i++) msg[i] = 32'h2200_0000 + 32'((i + 1) * 32'h0101);
        rx_delay = 8;
        build_exp(26);
        send(26, 1'b0, 0);
        compare_log("R2 two rounds");
        gap = log_cyc[4] - log_cyc[3];
        // R7
        chk(gap >= 9, "R7 second round waits for drain", 32'(gap), 32'd9);
        rx_delay = 0;
    endtask

    task automatic t_stall();
        msg[0] = 32'h0000_0077;
        force_stat = 1'b1;
        build_exp(4);
        send(4, 1'b0, 10);
        compare_log("R7 stall release");
    endtask

    task automatic t_zero_lead();
        msg[0] = 32'h0;
        msg[1] = 32'h1234_5678;
        msg[2] = 32'h9ABC_DEF0;
        send(12, 1'b0, 0);
        // R8
        chk(log_n == 0, "R8 no writes on zero lead", 32'(log_n), 32'd0);
        chk(rej_n == 1, "R8 reject pulse", 32'(rej_n), 32'd1);
        chk(done_n == 0, "R8 no done", 32'(done_n), 32'd0);
        // the stream must still be aligned for the next message
        msg[0] = 32'h5555_AAAA;
        msg[1] = 32'h0000_0003;
        build_exp(8);
        send(8, 1'b0, 0);
        compare_log("R8 next message");
    endtask

    task automatic t_zero_masked();
        msg[0] = 32'h0000_0100;
        send(1, 1'b0, 0);
        // R8 R6: lead word masked to one byte becomes zero
        chk(log_n == 0, "R8 masked zero no writes", 32'(log_n), 32'd0);
        chk(rej_n == 1, "R8 masked zero reject", 32'(rej_n), 32'd1);
    endtask

    task automatic t_len0();
        log_n = 0; rej_n = 0; done_n = 0;
        @(negedge clk);
        start = 1'b1;
        msg_len = '0;
        @(negedge clk);
        start = 1'b0;
        #1;
        // R9
        chk(reject == 1'b1, "R9 reject next cycle", 32'(reject), 32'd1);
        chk(busy == 1'b0 && word_ready == 1'b0, "R9 stays idle",
            {30'd0, busy, word_ready}, 32'd0);
        repeat (3) @(negedge clk);
        #1;
        chk(rej_n == 1 && log_n == 0, "R9 single pulse no writes", 32'(rej_n), 32'd1);
    endtask

    task automatic t_busy_start();
        msg[0] = 32'h0BAD_0001;
        msg[1] = 32'h0BAD_0002;
        build_exp(8);
        send(8, 1'b1, 0);
        // R10
        compare_log("R10 start while busy");
        repeat (4) @(negedge clk);
        #1;
        chk(busy == 1'b0 && log_n == exp_n, "R10 no second message", 32'(log_n), 32'(exp_n));
    endtask

    task automatic t_max();
        for (int i = 0; i < 64; i++) msg[i] = 32'h4000_0001 + 32'(i) * 32'h0101_0101;
        rx_delay = 2;
        build_exp(MAXB);
        send(MAXB, 1'b0, 0);
        // R2: 16 rounds of 4 windows
        compare_log("R2 max length");
        rx_delay = 0;
    endtask

    initial begin
        t_reset();
        t_single();
        t_full();
        t_partial();
        t_multi();
        t_stall();
        t_zero_lead();
        t_zero_masked();
        t_len0();
        t_busy_start();
        t_max();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule